// File: doc/BRIEF.md
# Instruction Memory Fill Controller

This block loads an instruction-side block RAM from a simple register bus, for systems where the memory holds no preloaded contents after configuration. Software first writes an init register. That write sets the 64-bit word address where loading starts. It also chooses which 32-bit half of that word receives the first fill write.

Each later write to a fill register turns into exactly one block RAM write. The target half alternates between the even half and the odd half of the 64-bit instruction word. The word address moves forward once both halves have been written.

The block runs entirely on the memory clock that the fetch path also uses. It accepts one bus request at a time and acknowledges each request with a single-cycle pulse.

Top module: `imem_fill_ctrl`

## Requirements
- R1: After reset, busAck, memEvenWe and memOddWe are low. Loading starts at word address 0 with the even half.
- R2: A request to bus address 0 (init register) loads the start word address from busWrData[MEM_AW:1]. It loads the starting half from busWrData[0], where 0 means even and 1 means odd. It is acknowledged in the cycle after the request is captured and writes nothing to memory.
- R3: A request to bus address 1 (fill register) produces exactly one memory write. Exactly one of memEvenWe and memOddWe is high, and only for the one cycle after the request is captured.
- R4: The even half is memWrData[31:0] and the odd half is memWrData[63:32]. The 32-bit fill data appears on the selected half, the other half is driven to zero, and its write enable stays low.
- R5: Successive fill writes alternate between the even and odd halves, starting from the half chosen by the last init write.
- R6: After a write to the odd half the word address increases by one, and after the last address it wraps to zero. A write to the even half leaves the word address unchanged.
- R7: A request to any other bus address writes nothing to memory. It leaves the address and the half selection unchanged, and it is still acknowledged.
- R8: For a fill write, busAck is a one-cycle pulse in the cycle after the memory write. Requests that arrive before busAck has been returned are ignored.
- R9: An init write at any point, including after an even-half write, replaces both the word address and the half selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, shared with instruction fetch |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | BUS_AW | Register-bus address of the request |
| busWrEn | input | 1 | Single-cycle write request strobe |
| busWrData | input | 32 | Register-bus write data |
| busAck | output | 1 | One-cycle acknowledge of an accepted request |
| memAddr | output | MEM_AW | Block RAM 64-bit word address |
| memWrData | output | 64 | Block RAM write data |
| memEvenWe | output | 1 | Write enable for bits 31:0 |
| memOddWe | output | 1 | Write enable for bits 63:32 |

## Verification
The hardest condition to create from the ports is an address wrap that lands on either half, followed by an init write that arrives while the half selector sits on the odd side. The bench uses an 8-word memory. For every start address and both starting halves, it writes the init register and then performs 19 fill writes, so every sweep wraps at least once. The next sweep then re-initialises from whatever state the previous one left.

A request is also pulsed while a fill write is in flight, to show that it is dropped.

// File: rtl/imem_fill_pkg.sv
package imem_fill_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_ACK} fillState_t;

  typedef struct packed {
    logic loadInit;
    logic captureFill;
    logic issueWrite;
  } fillStrobes_t;
endpackage

// File: rtl/imem_fill_ctrl_fsm.sv
module imem_fill_ctrl_fsm
  import imem_fill_pkg::*;
#(
  parameter int BUS_AW   = 4,
  parameter int INIT_REG = 0,
  parameter int FILL_REG = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  output logic              busAck,
  output fillStrobes_t      strobes
);
  localparam logic [BUS_AW-1:0] InitSel = BUS_AW'(INIT_REG);
  localparam logic [BUS_AW-1:0] FillSel = BUS_AW'(FILL_REG);

  fillState_t state, nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      ST_IDLE: if (busWrEn) begin
        if (busAddr == FillSel) begin
          strobes.captureFill = 1'b1;
          nextState = ST_WRITE;
        end else begin
          strobes.loadInit = (busAddr == InitSel);
          nextState = ST_ACK;
        end
      end
      ST_WRITE: begin
        strobes.issueWrite = 1'b1;
        nextState = ST_ACK;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busAck = (state == ST_ACK);

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R8
  ack_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueWrite |=> busAck);

  // R3
  capture_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureFill |=> strobes.issueWrite);
endmodule

// File: rtl/imem_fill_datapath.sv
module imem_fill_datapath
  import imem_fill_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobes_t      strobes,
  input  logic [31:0]       busWrData,
  output logic [MEM_AW-1:0] memAddr,
  output logic [63:0]       memWrData,
  output logic              memEvenWe,
  output logic              memOddWe
);
  logic [MEM_AW-1:0] wordAddr;
  logic              oddSel;
  logic [31:0]       fillData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddr <= '0;
      oddSel   <= 1'b0;
      fillData <= '0;
    end else begin
      if (strobes.loadInit) begin
        wordAddr <= busWrData[MEM_AW:1];
        oddSel   <= busWrData[0];
      end else if (strobes.issueWrite) begin
        oddSel <= ~oddSel;
        if (oddSel) wordAddr <= wordAddr + 1'b1;
      end
      if (strobes.captureFill) fillData <= busWrData;
    end
  end

  assign memAddr   = wordAddr;
  assign memWrData = oddSel ? {fillData, 32'h0} : {32'h0, fillData};
  assign memEvenWe = strobes.issueWrite & ~oddSel;
  assign memOddWe  = strobes.issueWrite & oddSel;

  // R3
  even_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEvenWe |=> !memEvenWe);

  // R3
  odd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memOddWe |=> !memOddWe);

  // R6
  odd_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    memOddWe |=> (memAddr == $past(memAddr) + 1'b1));

  // R6
  even_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEvenWe |=> $stable(memAddr));
endmodule

// File: rtl/imem_fill_ctrl.sv
module imem_fill_ctrl
  import imem_fill_pkg::*;
#(
  parameter int BUS_AW   = 4,
  parameter int MEM_AW   = 10,
  parameter int INIT_REG = 0,
  parameter int FILL_REG = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic              busAck,
  output logic [MEM_AW-1:0] memAddr,
  output logic [63:0]       memWrData,
  output logic              memEvenWe,
  output logic              memOddWe
);
  fillStrobes_t strobes;

  imem_fill_ctrl_fsm #(
    .BUS_AW(BUS_AW), .INIT_REG(INIT_REG), .FILL_REG(FILL_REG)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busAck(busAck), .strobes(strobes)
  );

  imem_fill_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .memAddr(memAddr), .memWrData(memWrData),
    .memEvenWe(memEvenWe), .memOddWe(memOddWe)
  );

  // R3
  one_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memEvenWe, memOddWe}));

  // R8
  no_write_during_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> !(memEvenWe || memOddWe));
endmodule

// File: tb/imem_fill_ctrl_test.sv
module imem_fill_ctrl_test;
  localparam int BUS_AW = 2;
  localparam int MEM_AW = 3;
  localparam int WORDS  = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [BUS_AW-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic              busAck;
  logic [MEM_AW-1:0] memAddr;
  logic [63:0]       memWrData;
  logic              memEvenWe, memOddWe;

  int total = 0;
  int bad = 0;
  int expAddr = 0;
  logic expOdd = 1'b0;
  int cycles = 0;
  bit finished = 1'b0;

  imem_fill_ctrl #(.BUS_AW(BUS_AW), .MEM_AW(MEM_AW)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busAck(busAck), .memAddr(memAddr),
    .memWrData(memWrData), .memEvenWe(memEvenWe), .memOddWe(memOddWe)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      summary();
    end
  end

  // register write that must not touch memory (init or unmapped address)
  task automatic plainWrite(input logic [BUS_AW-1:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    check({req, " idle ack"}, 64'(busAck), 64'd0);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check({req, " ack"}, 64'(busAck), 64'd1);
    check({req, " no write"}, 64'({memEvenWe, memOddWe}), 64'd0);
  endtask

  task automatic initWrite(input int a, input logic h);
    plainWrite(2'd0, 32'((a << 1) | int'(h)), "R2/R9");
    expAddr = a;
    expOdd = h;
  endtask

  task automatic fillWrite(input logic [31:0] d);
    @(negedge clk);
    check("R8 idle ack", 64'(busAck), 64'd0);
    busAddr = 2'd1; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R3/R5 enables", 64'({memEvenWe, memOddWe}), expOdd ? 64'd1 : 64'd2);
    check("R6 address", 64'(memAddr), 64'(expAddr));
    check("R4 data half", memWrData, expOdd ? {d, 32'h0} : {32'h0, d});
    check("R8 no early ack", 64'(busAck), 64'd0);
    @(negedge clk);
    check("R8 ack after write", 64'(busAck), 64'd1);
    check("R3 single write", 64'({memEvenWe, memOddWe}), 64'd0);
    if (expOdd) expAddr = (expAddr + 1) % WORDS;
    expOdd = ~expOdd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack", 64'(busAck), 64'd0);
    check("R1 enables", 64'({memEvenWe, memOddWe}), 64'd0);
    rstN = 1'b1;
    check("R1 address", 64'(memAddr), 64'd0);
    // R1: first fill after reset goes to word 0, even half
    fillWrite(32'hA5A5_0001);

    // R5 R6 R9: sweep every start address and both starting halves
    for (int a = 0; a < WORDS; a++) begin
      for (int h = 0; h < 2; h++) begin
        initWrite(a, h[0]);
        for (int k = 0; k < 2 * WORDS + 3; k++)
          fillWrite(32'((a << 24) ^ (h << 20) ^ (k * 32'h0101_0107)));
      end
    end

    // R7: unmapped addresses leave the fill position untouched
    initWrite(5, 1'b0);
    fillWrite(32'h1111_2222);
    plainWrite(2'd2, 32'hFFFF_FFFF, "R7");
    plainWrite(2'd3, 32'h0000_0000, "R7");
    fillWrite(32'h3333_4444);

    // R8: a request made while a fill is in flight is dropped
    @(negedge clk);
    busAddr = 2'd1; busWrData = 32'hDEAD_0001; busWrEn = 1'b1;
    @(negedge clk);
    busWrData = 32'hDEAD_0002;
    check("R8 first write", 64'({memEvenWe, memOddWe}), expOdd ? 64'd1 : 64'd2);
    @(negedge clk);
    busWrEn = 1'b0;
    check("R8 ack", 64'(busAck), 64'd1);
    @(negedge clk);
    check("R8 busy request dropped", 64'({memEvenWe, memOddWe, busAck}), 64'd0);
    if (expOdd) expAddr = (expAddr + 1) % WORDS;
    expOdd = ~expOdd;
    fillWrite(32'h5555_6666);

    summary();
  end
endmodule